// File: doc/BRIEF.md
# System Clock Source and Divider Unit

This unit derives four working clocks for a processor subsystem from three incoming reference clocks: an external reference, PLL A and PLL M. A first selector picks the main clock, either the external reference or PLL A. Three domain selectors then each pick one of three options for their own clock: the main clock, PLL M, or no clock at all. These three domains are the CPU, fast bus 0 and fast bus 2. Each domain is followed by an integer divider. A slow peripheral clock takes the fast bus 2 source and divides it with a divider of its own.

Everything is configured through one 32-bit control word written over a plain write port and always visible on a read port. A divider field can be changed freely, but the domain only adopts the new ratio at the end of a complete divided period, and only while that domain's change flag is set. Source changes go through a handover. The old clock is parked on its low phase before the new one is let through. No output ever carries a shortened pulse.

The incoming clocks are oversampled by the system clock `clk` through a synchroniser. The generated clocks are produced as registered levels in that domain.

Top module: `sysclk_gen`

## Requirements
- R1: After reset the control word reads 0x5500_0000. In that state the main selector is 1 (external reference), all three domain selectors are 1 (main clock), every divider field is 0 (divide by one), and the change flags and the gate bit are clear. Every output therefore runs at the external reference period.
- R2: When `wrEn` is high at a clock edge, `rdData` shows the complete written word from the next cycle on.
- R3: The main selector is bits 31:30. The value 1 selects the external reference and 2 selects PLL A. The values 0 and 3 give no main clock, so the main output and every domain fed from it stay low.
- R4: The domain selectors are bits 29:28 (CPU), 27:26 (fast bus 0) and 25:24 (fast bus 2). The value 1 selects the ungated main clock, 2 selects PLL M, and 0 or 3 hold that domain low.
- R5: The divider fields are bits 3:0 (CPU), 11:8 (fast bus 0), 15:12 (fast bus 2) and 19:16 (slow peripheral). A domain's output period equals (field + 1) times its source period.
- R6: The change flags are bit 22 (CPU), bit 21 (fast bus 0) and bit 20 (fast bus 2 and slow peripheral). A divider adopts its field only while its flag is set. With the flag clear, the ratio in use is kept even after the field is rewritten.
- R7: A new ratio is adopted only at the end of a complete divided period, at the moment the divider's count restarts.
- R8: The slow peripheral clock follows the fast bus 2 selector, including the stopped encodings, and applies its own divider field.
- R9: Setting bit 23 holds the main clock output low, and clearing it lets the output run again. The gate takes effect only during a low phase and does not affect the domains that use the main clock.
- R10: A selector change first parks the output on a low phase of the old source, and only re-enables it during a low phase of the new one. No output pulse, high or low, is shorter than the shortest phase of the sources involved.
- R11: Bits 7:4 are stored and read back but change no output, even while all change flags are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the sources and runs all state |
| rstN | input | 1 | Asynchronous active-low reset |
| extRefClk | input | 1 | External reference clock |
| pllAClk | input | 1 | PLL A output clock |
| pllMClk | input | 1 | PLL M output clock |
| wrEn | input | 1 | Write strobe for the control word |
| wrData | input | 32 | Control word to write |
| rdData | output | 32 | Current control word |
| mainClkOut | output | 1 | Gated main clock |
| cpuClkOut | output | 1 | Divided CPU clock |
| bus0ClkOut | output | 1 | Divided fast bus 0 clock |
| bus2ClkOut | output | 1 | Divided fast bus 2 clock |
| periphClkOut | output | 1 | Divided slow peripheral clock |

## Verification
The bench measures every output period in system cycles and tracks the shortest high and low pulse seen across each reconfiguration. A handover that switched on a high phase would show up as a pulse shorter than two cycles. Divider fields are rewritten with their change flags clear and then set. A design that ignored the flag, or loaded the field without adding one, would show the wrong period. The stopped selector encodings, the invalid main encodings and the gate bit are each applied while the other outputs keep running. The bench expects a silent output there, and a design that fell through to some source would keep toggling. A design that let the fast bus 2 change flag bypass the slow peripheral divider, or that took the cache field as the CPU ratio, would also fail a period check.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;
  localparam int REG_W         = 32;
  localparam int SEL_W         = 2;
  localparam int NUM_OPT       = 1 << SEL_W;
  localparam int DIV_W         = 4;
  localparam int NUM_DOM       = 3;
  localparam int NUM_DIV       = NUM_DOM + 1;
  localparam int NUM_SRC       = 3;
  localparam int SRC_EXT       = 0;
  localparam int SRC_PLLA      = 1;
  localparam int SRC_PLLM      = 2;
  localparam int MAIN_SEL_LSB  = 30;
  localparam int DOM_SEL_TOP   = 29;  // domain d selector at [DOM_SEL_TOP-2d -: SEL_W]
  localparam int MAIN_GATE_BIT = 23;
  localparam int CE_TOP        = 22;  // domain d change flag at CE_TOP-d
  localparam logic [REG_W-1:0] CTRL_RESET = 32'h5500_0000;

  // divider i sits in a nibble; the cache field at 7:4 is skipped
  function automatic int divLsb(int i);
    return (i == 0) ? 0 : DIV_W * (i + 1);
  endfunction

  // the slow peripheral divider shares the last domain
  function automatic int divDom(int i);
    return (i >= NUM_DOM) ? NUM_DOM - 1 : i;
  endfunction

  typedef struct packed {
    logic                            mainLvl;
    logic                            mainGateOpen;
    logic [NUM_DOM-1:0]              domLvl;
    logic [NUM_DIV-1:0]              loadOk;
    logic [NUM_DIV-1:0][DIV_W-1:0]   divField;
  } pathCtl_t;
endpackage

// File: rtl/sysclk_handover.sv
module sysclk_handover #(
  parameter int SEL_W = 2,
  parameter logic [SEL_W-1:0] RESET_SEL = '0
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [(1<<SEL_W)-1:0]   opts,
  input  logic [SEL_W-1:0]        reqSel,
  output logic [SEL_W-1:0]        curSel,
  output logic                    run,
  output logic                    lvl
);
  // park on a low phase of the old option, re-enable on a low phase of the new one
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curSel <= RESET_SEL;
      run    <= 1'b1;
    end else if (run) begin
      if (reqSel != curSel && !opts[curSel]) run <= 1'b0;
    end else if (!opts[reqSel]) begin
      curSel <= reqSel;
      run    <= 1'b1;
    end
  end

  assign lvl = run & opts[curSel];
endmodule

// File: rtl/sysclk_ctrl.sv
module sysclk_ctrl
  import sysclk_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          wrEn,
  input  logic [REG_W-1:0]              wrData,
  input  logic [NUM_SRC-1:0]            srcSync,
  output logic [REG_W-1:0]              ctrlReg,
  output pathCtl_t                      pathCtl,
  output logic [NUM_DOM:0][SEL_W-1:0]   hoSel,
  output logic [NUM_DOM:0]              hoRun
);
  logic [NUM_OPT-1:0]               mainOpts;
  logic                             mainLvl;
  logic                             gateOpen;
  logic [NUM_DOM-1:0][NUM_OPT-1:0]  domOpts;
  logic [NUM_DOM-1:0][SEL_W-1:0]    domReq;
  logic [NUM_DOM-1:0]               domLvl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     ctrlReg <= CTRL_RESET;
    else if (wrEn) ctrlReg <= wrData;
  end

  always_comb begin
    mainOpts           = '0;
    mainOpts[1]        = srcSync[SRC_EXT];
    mainOpts[2]        = srcSync[SRC_PLLA];
  end

  sysclk_handover #(
    .SEL_W     (SEL_W),
    .RESET_SEL (CTRL_RESET[MAIN_SEL_LSB +: SEL_W])
  ) u_mainHo (
    .clk    (clk),
    .rstN   (rstN),
    .opts   (mainOpts),
    .reqSel (ctrlReg[MAIN_SEL_LSB +: SEL_W]),
    .curSel (hoSel[0]),
    .run    (hoRun[0]),
    .lvl    (mainLvl)
  );

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    always_comb begin
      domOpts[d]    = '0;
      domOpts[d][1] = mainLvl;
      domOpts[d][2] = srcSync[SRC_PLLM];
    end
    assign domReq[d] = ctrlReg[DOM_SEL_TOP - 2*d -: SEL_W];

    sysclk_handover #(
      .SEL_W     (SEL_W),
      .RESET_SEL (CTRL_RESET[DOM_SEL_TOP - 2*d -: SEL_W])
    ) u_domHo (
      .clk    (clk),
      .rstN   (rstN),
      .opts   (domOpts[d]),
      .reqSel (domReq[d]),
      .curSel (hoSel[d+1]),
      .run    (hoRun[d+1]),
      .lvl    (domLvl[d])
    );
  end

  // gate follows its bit only while the main level is low
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         gateOpen <= 1'b1;
    else if (!mainLvl) gateOpen <= ~ctrlReg[MAIN_GATE_BIT];
  end

  always_comb begin
    pathCtl.mainLvl      = mainLvl;
    pathCtl.mainGateOpen = gateOpen;
    pathCtl.domLvl       = domLvl;
    for (int i = 0; i < NUM_DIV; i++) begin
      pathCtl.loadOk[i]   = ctrlReg[CE_TOP - divDom(i)];
      pathCtl.divField[i] = ctrlReg[divLsb(i) +: DIV_W];
    end
  end
endmodule

// File: rtl/sysclk_path.sv
module sysclk_path
  import sysclk_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_SRC-1:0]            srcRaw,
  input  pathCtl_t                      pathCtl,
  output logic [NUM_SRC-1:0]            srcSync,
  output logic                          mainClkOut,
  output logic [NUM_DIV-1:0]            divClkOut,
  output logic [NUM_DIV-1:0][DIV_W-1:0] actDiv,
  output logic [NUM_DIV-1:0][DIV_W-1:0] divCnt
);
  logic [NUM_SRC-1:0] syncPipe [SYNC_STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncPipe[s] <= '0;
    end else begin
      syncPipe[0] <= srcRaw;
      for (int s = 1; s < SYNC_STAGES; s++) syncPipe[s] <= syncPipe[s-1];
    end
  end
  assign srcSync = syncPipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) mainClkOut <= 1'b0;
    else       mainClkOut <= pathCtl.mainLvl & pathCtl.mainGateOpen;
  end

  for (genvar i = 0; i < NUM_DIV; i++) begin : g_div
    logic             srcLvl;
    logic             prevLvl;
    logic             outQ;
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] act;

    assign srcLvl = pathCtl.domLvl[divDom(i)];

    // count source falls; pass the high phase only on count zero
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        prevLvl <= 1'b0;
        outQ    <= 1'b0;
        cnt     <= '0;
        act     <= '0;
      end else begin
        prevLvl <= srcLvl;
        outQ    <= srcLvl & (cnt == '0);
        if (prevLvl && !srcLvl) begin
          if (cnt == act) begin
            cnt <= '0;
            if (pathCtl.loadOk[i]) act <= pathCtl.divField[i];
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
    end

    assign divClkOut[i] = outQ;
    assign actDiv[i]    = act;
    assign divCnt[i]    = cnt;
  end
endmodule

// File: rtl/sysclk_gen.sv
module sysclk_gen
  import sysclk_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        extRefClk,
  input  logic        pllAClk,
  input  logic        pllMClk,
  input  logic        wrEn,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic        mainClkOut,
  output logic        cpuClkOut,
  output logic        bus0ClkOut,
  output logic        bus2ClkOut,
  output logic        periphClkOut
);
  logic [NUM_SRC-1:0]            srcRaw;
  logic [NUM_SRC-1:0]            srcSync;
  pathCtl_t                      pathCtl;
  logic [NUM_DOM:0][SEL_W-1:0]   hoSel;
  logic [NUM_DOM:0]              hoRun;
  logic [NUM_DIV-1:0]            divClkOut;
  logic [NUM_DIV-1:0][DIV_W-1:0] actDiv;
  logic [NUM_DIV-1:0][DIV_W-1:0] divCnt;

  always_comb begin
    srcRaw           = '0;
    srcRaw[SRC_EXT]  = extRefClk;
    srcRaw[SRC_PLLA] = pllAClk;
    srcRaw[SRC_PLLM] = pllMClk;
  end

  sysclk_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrData  (wrData),
    .srcSync (srcSync),
    .ctrlReg (rdData),
    .pathCtl (pathCtl),
    .hoSel   (hoSel),
    .hoRun   (hoRun)
  );

  sysclk_path #(.SYNC_STAGES(SYNC_STAGES)) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .srcRaw     (srcRaw),
    .pathCtl    (pathCtl),
    .srcSync    (srcSync),
    .mainClkOut (mainClkOut),
    .divClkOut  (divClkOut),
    .actDiv     (actDiv),
    .divCnt     (divCnt)
  );

  assign cpuClkOut    = divClkOut[0];
  assign bus0ClkOut   = divClkOut[1];
  assign bus2ClkOut   = divClkOut[2];
  assign periphClkOut = divClkOut[3];
endmodule

// File: rtl/sysclk_chk.sv
module sysclk_chk
  import sysclk_pkg::*;
(
  input logic                          clk,
  input logic                          rstN,
  input logic                          wrEn,
  input logic [REG_W-1:0]              wrData,
  input logic [REG_W-1:0]              rdData,
  input pathCtl_t                      pathCtl,
  input logic [NUM_DOM:0][SEL_W-1:0]   hoSel,
  input logic [NUM_DOM:0]              hoRun,
  input logic [NUM_DIV-1:0][DIV_W-1:0] actDiv,
  input logic [NUM_DIV-1:0][DIV_W-1:0] divCnt
);
  // R2
  readback_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(wrEn) |-> (rdData == $past(wrData)));

  // R9
  gate_on_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pathCtl.mainGateOpen != $past(pathCtl.mainGateOpen)) |-> !$past(pathCtl.mainLvl));

  for (genvar k = 0; k <= NUM_DOM; k++) begin : g_ho
    // R10
    handover_parked_chk: assert property (@(posedge clk) disable iff (!rstN)
      (hoSel[k] != $past(hoSel[k])) |-> !$past(hoRun[k]));
  end

  for (genvar i = 0; i < NUM_DIV; i++) begin : g_dv
    // R6
    ratio_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
      (actDiv[i] != $past(actDiv[i])) |-> $past(pathCtl.loadOk[i]));
    // R7
    ratio_boundary_chk: assert property (@(posedge clk) disable iff (!rstN)
      (actDiv[i] != $past(actDiv[i])) |-> (divCnt[i] == '0));
    // R5
    count_range_chk: assert property (@(posedge clk) disable iff (!rstN)
      divCnt[i] <= actDiv[i]);
  end
endmodule

bind sysclk_gen sysclk_chk i_sysclk_chk (
  .clk     (clk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .wrData  (wrData),
  .rdData  (rdData),
  .pathCtl (pathCtl),
  .hoSel   (hoSel),
  .hoRun   (hoRun),
  .actDiv  (actDiv),
  .divCnt  (divCnt)
);

// File: tb/test_sysclk_gen.sv
`timescale 1ns/100ps
module test_sysclk_gen;
  localparam int REF_HALF  = 4;   // external reference period 8 cycles
  localparam int PLLA_HALF = 3;   // PLL A period 6 cycles
  localparam int PLLM_HALF = 2;   // PLL M period 4 cycles
  localparam int SETTLE    = 450;
  localparam int WINDOW    = 350;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        extRefClk = 1'b0, pllAClk = 1'b0, pllMClk = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        mainClkOut, cpuClkOut, bus0ClkOut, bus2ClkOut, periphClkOut;

  sysclk_gen i_sysclk_gen (
    .clk(clk), .rstN(rstN), .extRefClk(extRefClk), .pllAClk(pllAClk), .pllMClk(pllMClk),
    .wrEn(wrEn), .wrData(wrData), .rdData(rdData), .mainClkOut(mainClkOut),
    .cpuClkOut(cpuClkOut), .bus0ClkOut(bus0ClkOut), .bus2ClkOut(bus2ClkOut),
    .periphClkOut(periphClkOut)
  );

  always #2.5 clk = ~clk;

  initial forever begin repeat (REF_HALF)  @(negedge clk); extRefClk = ~extRefClk; end
  initial forever begin repeat (PLLA_HALF) @(negedge clk); pllAClk   = ~pllAClk;   end
  initial forever begin repeat (PLLM_HALF) @(negedge clk); pllMClk   = ~pllMClk;   end

  int nChk = 0, nFail = 0;
  bit done = 1'b0;
  logic [31:0] mreg;
  int mAct [4];
  string oName [5] = '{"main", "cpu", "bus0", "bus2", "periph"};

  // output monitor
  wire [4:0] outs = {periphClkOut, bus2ClkOut, bus0ClkOut, cpuClkOut, mainClkOut};
  logic [4:0] prevO = '0;
  int cyc = 0;
  int riseCnt [5], lastRise [5], lastPer [5], runLen [5], minHigh [5], minLow [5];

  initial for (int k = 0; k < 5; k++) begin
    riseCnt[k] = 0; lastRise[k] = 0; lastPer[k] = 0; runLen[k] = 0;
    minHigh[k] = 1000; minLow[k] = 1000;
  end

  always @(negedge clk) begin
    cyc++;
    for (int k = 0; k < 5; k++) begin
      if (outs[k] == prevO[k]) runLen[k]++;
      else begin
        if (prevO[k]) begin if (runLen[k] < minHigh[k]) minHigh[k] = runLen[k]; end
        else          begin if (runLen[k] < minLow[k])  minLow[k]  = runLen[k]; end
        runLen[k] = 1;
        if (outs[k]) begin
          riseCnt[k]++;
          lastPer[k]  = cyc - lastRise[k];
          lastRise[k] = cyc;
        end
      end
    end
    prevO = outs;
  end

  task automatic check(bit ok, string what, longint act, longint exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  function automatic int expPer(int k);
    int mainPer, dom, per;
    logic [1:0] sel;
    case (mreg[31:30])
      2'd1:    mainPer = 2 * REF_HALF;
      2'd2:    mainPer = 2 * PLLA_HALF;
      default: mainPer = 0;
    endcase
    if (k == 0) return mreg[23] ? 0 : mainPer;
    dom = (k == 4) ? 2 : k - 1;
    sel = mreg[29 - 2*dom -: 2];
    per = (sel == 2'd1) ? mainPer : (sel == 2'd2) ? 2 * PLLM_HALF : 0;
    return per * (mAct[k-1] + 1);
  endfunction

  task automatic wrReg(logic [31:0] v);
    int dom;
    @(negedge clk);
    wrEn = 1'b1; wrData = v;
    @(negedge clk);
    wrEn = 1'b0;
    check(rdData == v, "R2 readback", rdData, v);
    mreg = v;
    for (int i = 0; i < 4; i++) begin
      dom = (i == 3) ? 2 : i;
      if (v[22 - dom]) mAct[i] = (i == 0) ? int'(v[3:0]) : int'(v[4*(i+1) +: 4]);
    end
  endtask

  task automatic checkClocks(string why);
    int snap [5];
    int exp;
    @(posedge clk);
    for (int k = 0; k < 5; k++) begin minHigh[k] = 1000; minLow[k] = 1000; end
    repeat (SETTLE) @(posedge clk);
    for (int k = 0; k < 5; k++) snap[k] = riseCnt[k];
    repeat (WINDOW) @(posedge clk);
    for (int k = 0; k < 5; k++) begin
      exp = expPer(k);
      if (exp == 0)
        check(riseCnt[k] == snap[k], $sformatf("%s %s stopped (rises)", why, oName[k]),
              riseCnt[k] - snap[k], 0);
      else
        check((riseCnt[k] - snap[k] >= 2) && (lastPer[k] == exp),
              $sformatf("%s %s period", why, oName[k]), lastPer[k], exp);
      check(minHigh[k] >= 2 && minLow[k] >= 2,
            $sformatf("R10 %s %s shortest pulse", why, oName[k]),
            (minHigh[k] < minLow[k]) ? minHigh[k] : minLow[k], 2);
    end
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(32'd4711));
    mreg = 32'h5500_0000;
    for (int i = 0; i < 4; i++) mAct[i] = 0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(rdData == 32'h5500_0000, "R1 reset word", rdData, 32'h5500_0000);
    checkClocks("R1 reset defaults");

    wrReg(32'h6300_0000); checkClocks("R4 R8 domain selectors");
    wrReg(32'h9500_0000); checkClocks("R3 PLL A main");
    wrReg(32'h1500_0000); checkClocks("R3 main code 0");
    wrReg(32'hD500_0000); checkClocks("R3 main code 3");
    wrReg(32'h5580_0000); checkClocks("R9 main gate set");
    wrReg(32'h5500_0000); checkClocks("R9 main gate cleared");
    wrReg(32'h5503_0502); checkClocks("R6 flags clear");
    wrReg(32'h5573_0502); checkClocks("R5 R6 R8 flags set");
    wrReg(32'h5573_05F2); checkClocks("R11 cache field");
    wrReg(32'h6543_05FF); checkClocks("R5 R7 max ratio on PLL M");
    wrReg(32'h5543_05FF); checkClocks("R5 R7 max ratio on reference");

    for (int n = 0; n < 12; n++) begin
      v = $urandom;
      v[31:30] = 2'(1 + $urandom % 2);
      for (int d = 0; d < 3; d++) v[29 - 2*d -: 2] = 2'(1 + $urandom % 2);
      wrReg(v);
      checkClocks($sformatf("R3 R4 R5 R6 R7 R8 R9 random %0d", n));
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChk++; nFail++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", 150000, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  end
endmodule